// File: doc/BRIEF.md
# DRAM Bank Command Timing Tracker

This block watches one DRAM bank and, on every cycle, says whether the command that a scheduler presents may go out now. It follows the bank between two states: idle (all rows closed) and row-open. For each per-bank interval it keeps a separate down-counter. Each counter is loaded when the command that starts its interval is accepted. A request is accepted in the same cycle that it is judged legal. Timing values are run-time inputs given in clock cycles, so one netlist serves any speed grade.

A scheduler drives a request code, a row address and the timing values. It samples `cmd_ok` before the clock edge, and a request is consumed at the edge only when `cmd_ok` is high. The tracker also reports whether a row is open and which one. It raises `rd_valid` for one cycle at the point where read data is due. Reads may overlap, and each accepted read produces its own strobe.

Top module: `dram_bank_timer`

## Requirements
- R1: A read (code 2) or write (code 3) is accepted no earlier than max(t_rcd,1) cycles after the accepted activate (code 1).
- R2: A precharge (code 4) is accepted no earlier than max(t_ras,1) cycles after the accepted activate.
- R3: An activate is accepted no earlier than max(t_rp,1) cycles after the accepted precharge.
- R4: A precharge is accepted no earlier than BURST_LEN-1+max(t_wr,1) cycles after an accepted write, because the last beat of the burst leaves BURST_LEN-1 cycles after the write command.
- R5: Two accepted activates are at least max(t_rc,1) cycles apart.
- R6: After an accepted refresh (code 5), neither an activate nor another refresh is accepted before max(t_rfc,1) cycles.
- R7: `rd_valid` is high for exactly one cycle, max(t_cas,1) cycles after an accepted read.
- R8: An activate is legal only while the bank is idle. Read and write are legal only while a row is open and `req_row` equals the open row. Precharge is legal only while a row is open. A refused request (`cmd_refused` high) leaves `bank_open` and `open_row` unchanged.
- R9: With every timing value at zero, each command in the sequence activate, read, precharge, activate is accepted one cycle after the one before it.
- R10: A refresh is refused while a row is open. Once the bank is precharged, a refresh waits for tRP like an activate does.
- R11: After reset the bank is idle, `open_row` is 0, `rd_valid` is low, and an activate is legal at once.
- R12: Code 0 (no operation) raises neither `cmd_ok` nor `cmd_refused`. Codes 6 and 7 are always refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented |
| req_cmd | input | 3 | Request code: 0 none, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh |
| req_row | input | ROW_W | Row address of the request |
| t_rcd | input | T_W | Activate-to-column delay, in cycles |
| t_ras | input | T_W | Activate-to-precharge minimum, in cycles |
| t_rp | input | T_W | Precharge-to-activate delay, in cycles |
| t_wr | input | T_W | Write recovery after the last beat, in cycles |
| t_rc | input | T_W | Activate-to-activate minimum, in cycles |
| t_rfc | input | T_W | Refresh-to-activate delay, in cycles |
| t_cas | input | T_W | Read command to data latency, in cycles |
| cmd_ok | output | 1 | The current request is legal and is taken at the edge |
| cmd_refused | output | 1 | The current request is illegal and is dropped |
| bank_open | output | 1 | A row is open |
| open_row | output | ROW_W | The row most recently opened |
| rd_valid | output | 1 | Read data is due this cycle |

## Verification
Each interval is swept over the values 0, 1, 2, 3, 5 and 9, with every other timing value held at zero. The bench measures the smallest gap at which the bench's retrying request is accepted. Values 0 and 1 show the clamp to one cycle, and the larger values show that each counter runs on its own. The write-to-precharge sweep separates burst length from recovery time. The activate-to-activate sweep places a precharge in between, which shows where tRC, rather than tRAS plus tRP, sets the gap. Illegal sequences (a second activate, a read to the wrong row, a refresh while open, reserved codes) are held across a clock edge, and the state outputs are then read back to show that nothing changed.

// File: rtl/dram_bank_pkg.sv
package dram_bank_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5
  } bank_cmd_e;

  localparam int TI_RCD = 0;
  localparam int TI_RAS = 1;
  localparam int TI_RP  = 2;
  localparam int TI_WR  = 3;
  localparam int TI_RC  = 4;
  localparam int TI_RFC = 5;
  localparam int NUM_TIMERS = 6;
endpackage

// File: rtl/bank_countdown.sv
module bank_countdown #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - W'(1);
  end

  assign done = (cnt == '0);

  p_count_moves_r1: assert property (@(posedge clk) disable iff (rst)
    (!load && !done) |=> (cnt == $past(cnt) - W'(1)));
endmodule

// File: rtl/rd_latency_pipe.sv
module rd_latency_pipe #(
  parameter int T_W = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           fire,
  input  logic [T_W-1:0] lat,
  output logic           valid
);
  localparam int DEPTH = 1 << T_W;

  logic [DEPTH-1:0] sr;
  logic [T_W-1:0]   tap;

  assign tap = (lat == '0) ? '0 : lat - T_W'(1);

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= (sr >> 1) | (fire ? (DEPTH'(1) << tap) : '0);
  end

  assign valid = sr[0];

  p_cas_short_r7: assert property (@(posedge clk) disable iff (rst)
    (fire && lat <= T_W'(1)) |=> valid);
endmodule

// File: rtl/dram_bank_timer.sv
module dram_bank_timer
  import dram_bank_pkg::*;
#(
  parameter int ROW_W     = 14,
  parameter int T_W       = 6,
  parameter int BURST_LEN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [2:0]       req_cmd,
  input  logic [ROW_W-1:0] req_row,
  input  logic [T_W-1:0]   t_rcd,
  input  logic [T_W-1:0]   t_ras,
  input  logic [T_W-1:0]   t_rp,
  input  logic [T_W-1:0]   t_wr,
  input  logic [T_W-1:0]   t_rc,
  input  logic [T_W-1:0]   t_rfc,
  input  logic [T_W-1:0]   t_cas,
  output logic             cmd_ok,
  output logic             cmd_refused,
  output logic             bank_open,
  output logic [ROW_W-1:0] open_row,
  output logic             rd_valid
);
  localparam int CNT_W = T_W + $clog2(BURST_LEN) + 1;
  localparam int SW    = CNT_W + 1;

  function automatic logic [CNT_W-1:0] need(input logic [T_W-1:0] t);
    return (t == '0) ? CNT_W'(1) : CNT_W'(t);
  endfunction

  logic is_act, is_rd, is_wr, is_pre, is_ref, is_nop;
  logic legal;
  logic acc_act, acc_rd, acc_wr, acc_pre, acc_ref;
  logic [NUM_TIMERS-1:0] ld, done;
  logic [CNT_W-1:0]      ld_val [NUM_TIMERS];

  assign is_nop = (req_cmd == CMD_NOP);
  assign is_act = (req_cmd == CMD_ACT);
  assign is_rd  = (req_cmd == CMD_RD);
  assign is_wr  = (req_cmd == CMD_WR);
  assign is_pre = (req_cmd == CMD_PRE);
  assign is_ref = (req_cmd == CMD_REF);

  always_comb begin
    legal = 1'b0;
    if (is_act)
      legal = !bank_open && done[TI_RP] && done[TI_RC] && done[TI_RFC];
    else if (is_rd || is_wr)
      legal = bank_open && done[TI_RCD] && (req_row == open_row);
    else if (is_pre)
      legal = bank_open && done[TI_RAS] && done[TI_WR];
    else if (is_ref)
      legal = !bank_open && done[TI_RP] && done[TI_RFC];
  end

  assign cmd_ok      = req_valid && !is_nop && legal;
  assign cmd_refused = req_valid && !is_nop && !legal;

  assign acc_act = cmd_ok && is_act;
  assign acc_rd  = cmd_ok && is_rd;
  assign acc_wr  = cmd_ok && is_wr;
  assign acc_pre = cmd_ok && is_pre;
  assign acc_ref = cmd_ok && is_ref;

  // Each load value is the wait minus one, because the counter reaches zero one edge later.
  assign ld[TI_RCD] = acc_act;
  assign ld[TI_RAS] = acc_act;
  assign ld[TI_RC]  = acc_act;
  assign ld[TI_RP]  = acc_pre;
  assign ld[TI_WR]  = acc_wr;
  assign ld[TI_RFC] = acc_ref;

  assign ld_val[TI_RCD] = need(t_rcd) - CNT_W'(1);
  assign ld_val[TI_RAS] = need(t_ras) - CNT_W'(1);
  assign ld_val[TI_RC]  = need(t_rc)  - CNT_W'(1);
  assign ld_val[TI_RP]  = need(t_rp)  - CNT_W'(1);
  assign ld_val[TI_WR]  = CNT_W'(BURST_LEN - 1) + need(t_wr) - CNT_W'(1);
  assign ld_val[TI_RFC] = need(t_rfc) - CNT_W'(1);

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
    bank_countdown #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .load(ld[i]), .load_val(ld_val[i]), .done(done[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_open <= 1'b0;
      open_row  <= '0;
    end else if (acc_act) begin
      bank_open <= 1'b1;
      open_row  <= req_row;
    end else if (acc_pre) begin
      bank_open <= 1'b0;
    end
  end

  rd_latency_pipe #(.T_W(T_W)) u_rdp (
    .clk(clk), .rst(rst), .fire(acc_rd), .lat(t_cas), .valid(rd_valid)
  );

  // Cycle counters for the assertions, saturating; reset to "long ago".
  logic [SW-1:0] since_act, since_pre, since_wr, since_ref;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_act <= '1;
      since_pre <= '1;
      since_wr  <= '1;
      since_ref <= '1;
    end else begin
      since_act <= acc_act ? SW'(1) : ((since_act == '1) ? since_act : since_act + SW'(1));
      since_pre <= acc_pre ? SW'(1) : ((since_pre == '1) ? since_pre : since_pre + SW'(1));
      since_wr  <= acc_wr  ? SW'(1) : ((since_wr  == '1) ? since_wr  : since_wr  + SW'(1));
      since_ref <= acc_ref ? SW'(1) : ((since_ref == '1) ? since_ref : since_ref + SW'(1));
    end
  end

  p_rcd_gap_r1: assert property (@(posedge clk) disable iff (rst)
    (acc_rd || acc_wr) |-> (since_act >= SW'(need(t_rcd))));
  p_ras_gap_r2: assert property (@(posedge clk) disable iff (rst)
    acc_pre |-> (since_act >= SW'(need(t_ras))));
  p_rp_gap_r3: assert property (@(posedge clk) disable iff (rst)
    (acc_act || acc_ref) |-> (since_pre >= SW'(need(t_rp))));
  p_wr_gap_r4: assert property (@(posedge clk) disable iff (rst)
    acc_pre |-> (since_wr >= SW'(BURST_LEN - 1) + SW'(need(t_wr))));
  p_rc_gap_r5: assert property (@(posedge clk) disable iff (rst)
    acc_act |-> (since_act >= SW'(need(t_rc))));
  p_rfc_gap_r6: assert property (@(posedge clk) disable iff (rst)
    (acc_act || acc_ref) |-> (since_ref >= SW'(need(t_rfc))));
  p_open_row_r8: assert property (@(posedge clk) disable iff (rst)
    acc_act |=> (bank_open && open_row == $past(req_row)));
  p_refuse_still_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_refused && !acc_act && !acc_pre) |=> ($stable(bank_open) && $stable(open_row)));
  p_ok_xor_refused_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_ok, cmd_refused}));
endmodule

// File: tb/sim_dram_bank_timer.sv
module sim_dram_bank_timer;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 14;
  localparam int T_W = 6;
  localparam int BL = 4;

  logic clk = 0, rst = 1, req_valid = 0;
  logic [2:0] req_cmd = 0;
  logic [ROW_W-1:0] req_row = 0;
  logic [T_W-1:0] t_rcd = 0, t_ras = 0, t_rp = 0, t_wr = 0, t_rc = 0, t_rfc = 0, t_cas = 0;
  logic cmd_ok, cmd_refused, bank_open, rd_valid;
  logic [ROW_W-1:0] open_row;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_bank_timer #(.ROW_W(ROW_W), .T_W(T_W), .BURST_LEN(BL)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd), .req_row(req_row),
    .t_rcd(t_rcd), .t_ras(t_ras), .t_rp(t_rp), .t_wr(t_wr), .t_rc(t_rc), .t_rfc(t_rfc),
    .t_cas(t_cas), .cmd_ok(cmd_ok), .cmd_refused(cmd_refused), .bank_open(bank_open),
    .open_row(open_row), .rd_valid(rd_valid));

  function automatic int need(input int t);
    return (t == 0) ? 1 : t;
  endfunction

  task automatic chk(input bit good, input string tag, input int act, input int exp);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; req_valid = 0;
    @(negedge clk); rst = 0;
  endtask

  task automatic zero_params();
    t_rcd = 0; t_ras = 0; t_rp = 0; t_wr = 0; t_rc = 0; t_rfc = 0; t_cas = 0;
  endtask

  // Present a request every cycle until accepted; n = cycles since previous acceptance.
  task automatic issue(input logic [2:0] c, input logic [ROW_W-1:0] r, output int n);
    n = 0;
    forever begin
      @(negedge clk); req_valid = 1; req_cmd = c; req_row = r; #1; n++;
      if (cmd_ok || n > 400) break;
    end
    @(posedge clk); #1 req_valid = 0;
  endtask

  // Present once, held across an edge; report the flags.
  task automatic probe(input logic [2:0] c, input logic [ROW_W-1:0] r, output bit ok, output bit rf);
    @(negedge clk); req_valid = 1; req_cmd = c; req_row = r; #1;
    ok = cmd_ok; rf = cmd_refused;
    @(posedge clk); #1 req_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n, n2, k;
    bit ok, rf;
    int tv [6] = '{0, 1, 2, 3, 5, 9};

    do_reset();
    // R11: reset state
    #1;
    chk(bank_open == 0, "R11 bank_open", bank_open, 0);
    chk(open_row == 0, "R11 open_row", open_row, 0);
    chk(rd_valid == 0, "R11 rd_valid", rd_valid, 0);
    req_valid = 1; req_cmd = 1; #1;
    chk(cmd_ok == 1, "R11 act legal", cmd_ok, 1);
    req_valid = 0;

    // R9: all zero timings
    zero_params(); do_reset();
    issue(1, 3, n);
    issue(2, 3, n); chk(n == 1, "R9 act->rd", n, 1);
    issue(4, 3, n); chk(n == 1, "R9 rd->pre", n, 1);
    issue(1, 3, n); chk(n == 1, "R9 pre->act", n, 1);

    foreach (tv[i]) begin
      int t = tv[i];
      // R1
      zero_params(); t_rcd = T_W'(t); do_reset();
      issue(1, 7, n); issue(2, 7, n);
      chk(n == need(t), "R1 act->rd", n, need(t));
      zero_params(); t_rcd = T_W'(t); do_reset();
      issue(1, 7, n); issue(3, 7, n);
      chk(n == need(t), "R1 act->wr", n, need(t));
      // R2
      zero_params(); t_ras = T_W'(t); do_reset();
      issue(1, 9, n); issue(4, 9, n);
      chk(n == need(t), "R2 act->pre", n, need(t));
      // R3
      zero_params(); t_rp = T_W'(t); do_reset();
      issue(1, 9, n); issue(4, 9, n); issue(1, 10, n);
      chk(n == need(t), "R3 pre->act", n, need(t));
      // R4
      zero_params(); t_wr = T_W'(t); do_reset();
      issue(1, 4, n); issue(3, 4, n); issue(4, 4, n);
      chk(n == BL - 1 + need(t), "R4 wr->pre", n, BL - 1 + need(t));
      // R5
      zero_params(); t_rc = T_W'(t); do_reset();
      issue(1, 2, n); issue(4, 2, n); issue(1, 8, n2);
      chk(n + n2 == ((need(t) > 2) ? need(t) : 2), "R5 act->act", n + n2,
          (need(t) > 2) ? need(t) : 2);
      // R6
      zero_params(); t_rfc = T_W'(t); do_reset();
      issue(5, 0, n); issue(1, 1, n);
      chk(n == need(t), "R6 ref->act", n, need(t));
      zero_params(); t_rfc = T_W'(t); do_reset();
      issue(5, 0, n); issue(5, 0, n);
      chk(n == need(t), "R6 ref->ref", n, need(t));
      // R7
      zero_params(); t_cas = T_W'(t); do_reset();
      issue(1, 5, n); issue(2, 5, n);
      k = 0;
      forever begin
        @(negedge clk); k++;
        if (rd_valid || k > 100) break;
      end
      chk(k == need(t), "R7 cas latency", k, need(t));
      @(negedge clk);
      chk(rd_valid == 0, "R7 single pulse", rd_valid, 0);
    end

    // R7: two overlapping reads give two strobes
    zero_params(); t_cas = 4; do_reset();
    issue(1, 5, n); issue(2, 5, n); issue(2, 5, n);
    k = 0;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk); if (rd_valid) k++;
    end
    chk(k == 2, "R7 overlapping reads", k, 2);

    // R8: state rules and refusals
    zero_params(); do_reset();
    probe(2, 5, ok, rf);
    chk(rf == 1 && ok == 0, "R8 read while idle refused", rf, 1);
    probe(4, 5, ok, rf);
    chk(rf == 1, "R8 precharge while idle refused", rf, 1);
    #1; chk(bank_open == 0, "R8 idle kept", bank_open, 0);
    issue(1, 5, n);
    #1; chk(bank_open == 1 && open_row == 5, "R8 open row", open_row, 5);
    probe(1, 6, ok, rf);
    chk(rf == 1, "R8 second act refused", rf, 1);
    #1; chk(open_row == 5, "R8 row unchanged after refused act", open_row, 5);
    probe(2, 6, ok, rf);
    chk(rf == 1, "R8 read to other row refused", rf, 1);
    probe(3, 5, ok, rf);
    chk(ok == 1, "R8 write to open row taken", ok, 1);
    #1; chk(bank_open == 1 && open_row == 5, "R8 still open", bank_open, 1);

    // R10: refresh rules
    zero_params(); t_rp = 3; do_reset();
    issue(1, 2, n);
    probe(5, 0, ok, rf);
    chk(rf == 1, "R10 refresh while open refused", rf, 1);
    #1; chk(bank_open == 1, "R10 bank stays open", bank_open, 1);
    issue(4, 2, n); issue(5, 0, n);
    chk(n == 3, "R10 pre->ref", n, 3);

    // R12: reserved codes and no-op
    zero_params(); do_reset();
    probe(6, 0, ok, rf);
    chk(rf == 1 && ok == 0, "R12 code 6 refused", rf, 1);
    probe(7, 0, ok, rf);
    chk(rf == 1 && ok == 0, "R12 code 7 refused", rf, 1);
    probe(0, 0, ok, rf);
    chk(rf == 0 && ok == 0, "R12 nop silent", {ok, rf}, 0);
    #1; chk(bank_open == 0, "R12 state idle", bank_open, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule